// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes the octet stream that a deframer produces for one serial channel and stores each frame in memory buffers that software provides through a ring of descriptors. Each descriptor names one buffer and holds a status and length word. The writer takes descriptors in ring order, fills each buffer up to a programmed buffer size, and moves to the next descriptor when a frame does not fit. When the frame ends, it appends the received check sequence and closes the last buffer with the frame's status.

Frames longer than a programmed maximum are truncated in memory. Their length field still gives the full count. An optional four-byte stamp can be placed at the head of each frame's first buffer. When no empty descriptor is available, the writer stalls the stream and polls the descriptor until software hands it back. A one-cycle pulse carrying the channel number marks each completed frame. The configuration inputs must stay stable while a frame is in progress. The frame limit must be at least 1. The buffer size must be a multiple of 8 bytes and at least 8.

Top module: `rxbd_ring_writer`

## Requirements
- R1: A descriptor is two 32-bit words. Word 0 holds status in bits 31:16 and length in bits 15:0. Word 1 holds the buffer byte address, which is word aligned. A descriptor is used only when status bit 15 (empty) is 1. While the next descriptor has empty clear, `in_ready` stays 0 and nothing is written to memory. The writer continues once software sets the bit. A descriptor that the frame does not need is left unchanged.
- R2: Stored bytes go to consecutive byte addresses from the buffer address. Byte address a is lane a mod 4 of word a/4, and lane 0 is bits 7:0.
- R3: A buffer takes at most `cfg_buf_max` bytes. If another byte must be stored after the buffer is full, the buffer is closed with length `cfg_buf_max`, with empty and last cleared, and the frame continues in the next descriptor.
- R4: Descriptor i is at word address `cfg_ring_base + 2*i`. The index starts at 0 and increases by one for each closed descriptor. After a descriptor whose status bit 13 (wrap) is 1, the index returns to 0.
- R5: After the final data byte, the check value from `in_crc` is stored: the low 16 bits (2 bytes) or all 32 bits (4 bytes) when `cfg_crc_wide` is 1. The most significant byte comes first. These bytes count toward the frame length.
- R6: The final buffer of a frame is closed with empty cleared, bit 11 (last) set, the wrap bit kept, and the length equal to the frame's octet count (data plus check bytes). All other status bits are 0.
- R7: A frame octet at position p (counted from 0) is stored only if p is less than `cfg_frame_max` rounded up to a multiple of 4. If the octet count exceeds `cfg_frame_max`, the final status has bit 5 set. The length field still gives the full count.
- R8: `in_nonoct` on the last beat sets final status bit 4. `in_crc_err` on the last beat sets final status bit 2.
- R9: When `cfg_stamp_en` is 1, the 4 bytes of `stamp_value`, most significant first, are stored at the start of the frame's first buffer. They occupy buffer space but count toward neither the frame length nor the frame limit.
- R10: `done_valid` pulses for one cycle, with `done_chan` equal to `cfg_chan`, in the cycle after the final status write.
- R11: While reset is active and right after it, `in_ready`, `mem_en` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | AW | Word address of descriptor 0 |
| cfg_buf_max | input | LW | Bytes per buffer (multiple of 8) |
| cfg_frame_max | input | LW | Maximum frame octet count |
| cfg_crc_wide | input | 1 | 1: 32-bit check value, 0: 16-bit |
| cfg_stamp_en | input | 1 | Store stamp at frame head |
| stamp_value | input | 32 | Stamp to store |
| cfg_chan | input | CHW | Channel number reported on completion |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last data byte of frame |
| in_crc | input | 32 | Received check value, valid with in_last |
| in_crc_err | input | 1 | Check failed, valid with in_last |
| in_nonoct | input | 1 | Frame bit count not a multiple of 8, valid with in_last |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read |
| done_valid | output | 1 | Frame complete pulse |
| done_chan | output | CHW | Channel of completed frame |

## Verification
A byte is written to memory at the same clock edge that accepts it from the stream. A descriptor read returns one cycle after it is requested. The completion pulse appears one cycle after the final status write. The bench therefore drives and samples on the falling edge, waits for the completion pulse, and only then inspects the modelled memory. By that point every status word and byte of the frame is settled. The stall case is observed over a fixed window of falling edges, during which `in_ready` and the memory write count must stay at zero.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  // status field bit positions (bits of word0[31:16])
  localparam int STAT_E  = 15;
  localparam int STAT_W  = 13;
  localparam int STAT_L  = 11;
  localparam int STAT_LG = 5;
  localparam int STAT_NO = 4;
  localparam int STAT_CR = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH0, S_FETCH1, S_FETCH2, S_TS, S_DATA, S_CRC, S_CLOSE
  } wr_state_t;

  function automatic logic [15:0] close_status(input logic wrap, input logic fin,
                                               input logic lg, input logic no,
                                               input logic cr);
    logic [15:0] s;
    s = '0;
    s[STAT_W]  = wrap;
    s[STAT_L]  = fin;
    s[STAT_LG] = fin & lg;
    s[STAT_NO] = fin & no;
    s[STAT_CR] = fin & cr;
    return s;
  endfunction
endpackage

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] desc_addr
);
  localparam int IW = AW - 1;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (advance) idx <= wrap ? '0 : idx + 1'b1;
  end

  assign desc_addr = base + {idx, 1'b0};

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
    (advance && wrap) |=> (desc_addr == base)); // R4
endmodule

// File: rtl/rxbd_len_track.sv
module rxbd_len_track #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [LW-1:0] limit,
  output logic [LW-1:0] len,
  output logic          keep,
  output logic          over
);
  localparam logic [LW-1:0] LEN_MAX = '1;
  logic [LW:0] lim_rounded;

  always_ff @(posedge clk) begin
    if (rst || clear) len <= '0;
    else if (step && len != LEN_MAX) len <= len + 1'b1;
  end

  always_comb begin
    lim_rounded = ({1'b0, limit} + (LW+1)'(3)) & ~(LW+1)'(3);
    keep = {1'b0, len} < lim_rounded;
    over = len > limit;
  end

  AST_KEEP_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!keep && !clear) |=> !keep); // R7
endmodule

// File: rtl/rxbd_byte_lane.sv
module rxbd_byte_lane #(
  parameter int AW = 10
) (
  input  logic [AW+1:0] byte_addr,
  input  logic [7:0]    byte_val,
  output logic [AW-1:0] word_addr,
  output logic [3:0]    be,
  output logic [31:0]   wdata
);
  assign word_addr = byte_addr[AW+1:2];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign be[g]           = (byte_addr[1:0] == 2'(g));
    assign wdata[8*g +: 8] = byte_val;
  end
endmodule

// File: rtl/rxbd_ring_writer.sv
module rxbd_ring_writer
  import rxbd_pkg::*;
#(
  parameter int AW  = 10,
  parameter int LW  = 16,
  parameter int CHW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  cfg_ring_base,
  input  logic [LW-1:0]  cfg_buf_max,
  input  logic [LW-1:0]  cfg_frame_max,
  input  logic           cfg_crc_wide,
  input  logic           cfg_stamp_en,
  input  logic [31:0]    stamp_value,
  input  logic [CHW-1:0] cfg_chan,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           in_last,
  input  logic [31:0]    in_crc,
  input  logic           in_crc_err,
  input  logic           in_nonoct,
  output logic           mem_en,
  output logic           mem_we,
  output logic [3:0]     mem_be,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  output logic           done_valid,
  output logic [CHW-1:0] done_chan
);
  localparam int STAT_OFS = 16;

  wr_state_t     state, ret_state, slot_state;
  logic          buf_open;
  logic [AW+1:0] buf_addr;
  logic [LW-1:0] buf_cnt;
  logic          desc_wrap;
  logic [1:0]    ts_cnt, crc_cnt, crc_last;
  logic [31:0]   crc_reg, crc_sel;
  logic          fl_no, fl_cr, close_final;

  logic [AW-1:0] desc_addr;
  logic [LW-1:0] frame_len;
  logic          keep, over, len_clear, len_step;
  logic [AW-1:0] lane_addr;
  logic [3:0]    lane_be;
  logic [31:0]   lane_data, close_word;
  logic [7:0]    cur_byte;
  logic          buf_full, can_write, need_slot, wr_byte;
  logic          rd_word0, rd_word1, close_wr, data_hs, crc_adv;

  rxbd_ring_ptr #(.AW(AW)) u_ring (
    .clk(clk), .rst(rst), .base(cfg_ring_base), .advance(close_wr),
    .wrap(desc_wrap), .desc_addr(desc_addr)
  );

  rxbd_len_track #(.LW(LW)) u_len (
    .clk(clk), .rst(rst), .clear(len_clear), .step(len_step),
    .limit(cfg_frame_max), .len(frame_len), .keep(keep), .over(over)
  );

  rxbd_byte_lane #(.AW(AW)) u_lane (
    .byte_addr(buf_addr), .byte_val(cur_byte), .word_addr(lane_addr),
    .be(lane_be), .wdata(lane_data)
  );

  always_comb begin
    buf_full   = buf_cnt >= cfg_buf_max;
    can_write  = buf_open && !buf_full;
    slot_state = buf_open ? S_CLOSE : S_FETCH0;
    crc_sel    = cfg_crc_wide ? crc_reg : {crc_reg[15:0], 16'h0000};
    crc_last   = cfg_crc_wide ? 2'd3 : 2'd1;

    case (state)
      S_TS:    cur_byte = 8'(stamp_value >> {~ts_cnt, 3'b000});
      S_CRC:   cur_byte = 8'(crc_sel >> {~crc_cnt, 3'b000});
      default: cur_byte = in_data;
    endcase

    case (state)
      S_TS:    need_slot = 1'b1;
      S_DATA:  need_slot = in_valid && keep;
      S_CRC:   need_slot = keep;
      default: need_slot = 1'b0;
    endcase

    wr_byte   = need_slot && can_write;
    in_ready  = (state == S_DATA) && (!keep || can_write);
    data_hs   = in_valid && in_ready;
    crc_adv   = (state == S_CRC) && (!keep || can_write);
    len_step  = data_hs || crc_adv;
    len_clear = (state == S_IDLE);
    rd_word0  = (state == S_FETCH0);
    rd_word1  = (state == S_FETCH1) && mem_rdata[STAT_OFS+STAT_E];
    close_wr  = (state == S_CLOSE);

    close_word = {close_status(desc_wrap, close_final, over, fl_no, fl_cr),
                  close_final ? frame_len : buf_cnt};

    mem_en    = rd_word0 || rd_word1 || wr_byte || close_wr;
    mem_we    = wr_byte || close_wr;
    mem_be    = close_wr ? 4'hF : (wr_byte ? lane_be : 4'h0);
    mem_wdata = close_wr ? close_word : lane_data;
    if (rd_word0 || close_wr) mem_addr = desc_addr;
    else if (rd_word1)        mem_addr = desc_addr + 1'b1;
    else                      mem_addr = lane_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ret_state   <= S_IDLE;
      buf_open    <= 1'b0;
      buf_addr    <= '0;
      buf_cnt     <= '0;
      desc_wrap   <= 1'b0;
      ts_cnt      <= '0;
      crc_cnt     <= '0;
      crc_reg     <= '0;
      fl_no       <= 1'b0;
      fl_cr       <= 1'b0;
      close_final <= 1'b0;
      done_valid  <= 1'b0;
      done_chan   <= '0;
    end else begin
      done_valid <= 1'b0;
      if (wr_byte) begin
        buf_addr <= buf_addr + 1'b1;
        buf_cnt  <= buf_cnt + 1'b1;
      end
      case (state)
        S_IDLE: if (in_valid) begin
          ts_cnt  <= '0;
          crc_cnt <= '0;
          fl_no   <= 1'b0;
          fl_cr   <= 1'b0;
          state   <= cfg_stamp_en ? S_TS : S_DATA;
        end
        S_FETCH0: state <= S_FETCH1;
        S_FETCH1: begin
          if (mem_rdata[STAT_OFS+STAT_E]) begin
            desc_wrap <= mem_rdata[STAT_OFS+STAT_W];
            state     <= S_FETCH2;
          end else begin
            state <= S_FETCH0;
          end
        end
        S_FETCH2: begin
          buf_addr <= mem_rdata[AW+1:0];
          buf_cnt  <= '0;
          buf_open <= 1'b1;
          state    <= ret_state;
        end
        S_TS: begin
          if (wr_byte) begin
            ts_cnt <= ts_cnt + 1'b1;
            if (ts_cnt == 2'd3) state <= S_DATA;
          end else begin
            ret_state   <= state;
            close_final <= 1'b0;
            state       <= slot_state;
          end
        end
        S_DATA: begin
          if (data_hs && in_last) begin
            crc_reg <= in_crc;
            fl_no   <= in_nonoct;
            fl_cr   <= in_crc_err;
            crc_cnt <= '0;
            state   <= S_CRC;
          end else if (need_slot && !can_write) begin
            ret_state   <= state;
            close_final <= 1'b0;
            state       <= slot_state;
          end
        end
        S_CRC: begin
          if (crc_adv) begin
            crc_cnt <= crc_cnt + 1'b1;
            if (crc_cnt == crc_last) begin
              close_final <= 1'b1;
              state       <= S_CLOSE;
            end
          end else begin
            ret_state   <= state;
            close_final <= 1'b0;
            state       <= slot_state;
          end
        end
        S_CLOSE: begin
          buf_open <= 1'b0;
          if (close_final) begin
            done_valid <= 1'b1;
            done_chan  <= cfg_chan;
            state      <= S_IDLE;
          end else begin
            state <= ret_state;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH1 && !mem_rdata[STAT_OFS+STAT_E]) |=> !mem_we); // R1
  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (rst)
    buf_open |-> (buf_cnt <= cfg_buf_max)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R10
  AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(mem_we && mem_be == 4'hF)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!done_valid && !in_ready)); // R11
endmodule

// File: tb/rxbd_ring_writer_tb.sv
module rxbd_ring_writer_tb;
  localparam int AW = 10, LW = 16, CHW = 8;
  localparam int B_E = 31, B_W = 29, B_L = 27, B_LG = 21, B_NO = 20, B_CR = 18;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [AW-1:0] cfg_ring_base = '0;
  logic [LW-1:0] cfg_buf_max = 16, cfg_frame_max = 100;
  logic cfg_crc_wide = 0, cfg_stamp_en = 0;
  logic [31:0] stamp_value = 32'h0;
  logic [CHW-1:0] cfg_chan = 8'h00;
  logic in_valid = 0, in_last = 0, in_crc_err = 0, in_nonoct = 0;
  logic [7:0] in_data = 0;
  logic [31:0] in_crc = 0;
  logic in_ready, mem_en, mem_we, done_valid;
  logic [3:0] mem_be;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [CHW-1:0] done_chan;

  rxbd_ring_writer #(.AW(AW), .LW(LW), .CHW(CHW)) u_dut (
    .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_buf_max(cfg_buf_max),
    .cfg_frame_max(cfg_frame_max), .cfg_crc_wide(cfg_crc_wide), .cfg_stamp_en(cfg_stamp_en),
    .stamp_value(stamp_value), .cfg_chan(cfg_chan), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_crc(in_crc), .in_crc_err(in_crc_err),
    .in_nonoct(in_nonoct), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .done_chan(done_chan)
  );

  logic [31:0] ram [0:(1<<AW)-1];
  int n_wr = 0, n_done = 0, n_chk = 0, n_err = 0, ridx = 0;
  logic [7:0] fr [0:127];
  logic [7:0] es [0:299];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int g = 0; g < 4; g++) if (mem_be[g]) ram[mem_addr][8*g +: 8] <= mem_wdata[8*g +: 8];
        n_wr <= n_wr + 1;
      end else mem_rdata <= ram[mem_addr];
    end
    if (done_valid) n_done <= n_done + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input int a);
    return ram[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic arm_ring();
    for (int i = 0; i < 4; i++) begin
      ram[2*i] = (32'h1 << B_E) | ((i == 3) ? (32'h1 << B_W) : 32'h0);
      ram[2*i+1] = 32'(256 * (i + 1));
      for (int w = 0; w < 64; w++) ram[64*(i+1) + w] = 32'hA5A5A5A5;
    end
  endtask

  task automatic send_frame(input int n, input logic ce, input logic no, input logic [31:0] crc);
    for (int k = 0; k < n; k++) begin
      in_valid = 1; in_data = fr[k]; in_last = (k == n - 1);
      in_crc = crc; in_crc_err = ce; in_nonoct = no;
      while (1) begin
        #1;
        if (in_ready) begin @(negedge clk); break; end
        @(negedge clk);
      end
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done_valid && t < 3000) begin @(negedge clk); t++; end
    if (!done_valid) chk("R10 completion pulse", 0, 1);
    else chk("R10 channel on pulse", 32'(done_chan), 32'(cfg_chan));
    @(negedge clk);
    chk("R10 single pulse", 32'(done_valid), 0);
  endtask

  task automatic check_frame(input int n, input logic ce, input logic no, input logic [31:0] crc);
    int tsn, cn, oct, lim4, k, tt, nb, idx, cnt, bad, badpos, base, fin;
    logic [31:0] csel, expw;
    tsn = cfg_stamp_en ? 4 : 0;
    cn = cfg_crc_wide ? 4 : 2;
    oct = n + cn;
    lim4 = (int'(cfg_frame_max) + 3) / 4 * 4;
    k = (oct < lim4) ? oct : lim4;
    tt = tsn + k;
    csel = cfg_crc_wide ? crc : {crc[15:0], 16'h0};
    for (int q = 0; q < tsn; q++) es[q] = stamp_value[31-8*q -: 8];
    for (int q = 0; q < k; q++) es[tsn+q] = (q < n) ? fr[q] : csel[31-8*(q-n) -: 8];
    nb = (tt + int'(cfg_buf_max) - 1) / int'(cfg_buf_max);
    for (int j = 0; j < nb; j++) begin
      idx = (ridx + j) % 4;
      fin = (j == nb - 1);
      expw = ((idx == 3) ? (32'h1 << B_W) : 0);
      if (fin) begin
        expw |= 32'h1 << B_L;
        if (oct > int'(cfg_frame_max)) expw |= 32'h1 << B_LG;
        if (no) expw |= 32'h1 << B_NO;
        if (ce) expw |= 32'h1 << B_CR;
        expw |= 32'(oct & 16'hFFFF);
      end else expw |= 32'(cfg_buf_max);
      chk(fin ? "R6 R7 R8 final descriptor word" : "R3 R4 full descriptor word", ram[2*idx], expw);
      cnt = fin ? (tt - j * int'(cfg_buf_max)) : int'(cfg_buf_max);
      base = 256 * (idx + 1);
      bad = 0; badpos = -1;
      for (int b = 0; b < 256; b++) begin
        if (b < cnt) begin
          if (rb(base + b) !== es[j*int'(cfg_buf_max) + b]) begin bad++; if (badpos < 0) badpos = b; end
        end else if (rb(base + b) !== 8'hA5) begin bad++; if (badpos < 0) badpos = b; end
      end
      if (badpos < 0) badpos = 0;
      chk("R2 R5 R7 R9 buffer bytes", 32'(rb(base + badpos)),
          32'((badpos < cnt) ? es[j*int'(cfg_buf_max) + badpos] : 8'hA5));
    end
    if (nb < 4) chk("R1 unused descriptor left empty", 32'(ram[2*((ridx + nb) % 4)][B_E]), 1);
    ridx = (ridx + nb) % 4;
  endtask

  task automatic run_frame(input int n, input int bm, input int fm, input logic ts,
                           input logic c32, input logic ce, input logic no);
    int tt, lim4, oct;
    logic [31:0] crc;
    oct = n + (c32 ? 4 : 2);
    lim4 = (fm + 3) / 4 * 4;
    tt = (ts ? 4 : 0) + ((oct < lim4) ? oct : lim4);
    while ((tt + bm - 1) / bm > 4) bm += 8;
    cfg_buf_max = LW'(bm); cfg_frame_max = LW'(fm);
    cfg_stamp_en = ts; cfg_crc_wide = c32;
    stamp_value = $urandom; cfg_chan = 8'($urandom);
    crc = $urandom;
    for (int q = 0; q < n; q++) fr[q] = 8'($urandom);
    arm_ring();
    send_frame(n, ce, no, crc);
    wait_done();
    check_frame(n, ce, no, crc);
  endtask

  initial begin
    int seed, w0, rdy_seen, done0;
    seed = $urandom(32'h5EED1234);
    for (int i = 0; i < (1 << AW); i++) ram[i] = 0;
    repeat (4) @(negedge clk);
    chk("R11 in_ready in reset", 32'(in_ready), 0);
    chk("R11 mem_en in reset", 32'(mem_en), 0);
    rst = 0;
    @(negedge clk);
    chk("R11 done after reset", 32'(done_valid), 0);
    chk("R11 mem_en after reset", 32'(mem_en), 0);

    run_frame(12, 16, 100, 0, 0, 0, 0);   // single buffer, 16-bit check: R2 R5 R6
    run_frame(14, 8, 100, 0, 0, 0, 0);    // exactly two full buffers: R3
    run_frame(40, 16, 21, 0, 1, 0, 0);    // oversize truncated at 24: R7
    run_frame(10, 8, 100, 1, 1, 1, 1);    // stamp and both flags: R8 R9

    // stall on a descriptor still owned by software: R1
    cfg_buf_max = 16; cfg_frame_max = 100; cfg_stamp_en = 0; cfg_crc_wide = 0; cfg_chan = 8'h3C;
    for (int q = 0; q < 6; q++) fr[q] = 8'(q + 1);
    arm_ring();
    ram[2*ridx][B_E] = 1'b0;
    w0 = n_wr; rdy_seen = 0; done0 = n_done;
    fork
      send_frame(6, 0, 0, 32'h0000BEEF);
      begin
        repeat (30) begin @(negedge clk); if (in_ready) rdy_seen++; end
        chk("R1 no write while stalled", 32'(n_wr - w0), 0);
        chk("R1 ready low while stalled", 32'(rdy_seen), 0);
        ram[2*ridx][B_E] = 1'b1;
      end
    join
    wait_done();
    check_frame(6, 0, 0, 32'h0000BEEF);
    chk("R10 one pulse per frame", 32'(n_done - done0), 1);

    for (int r = 0; r < 12; r++)
      run_frame(1 + int'($urandom % 70), 8 * (1 + int'($urandom % 3)), 4 + int'($urandom % 70),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule